// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in packed BCD and makes it visible to software through a pair of byte ports. The first port is an index port. A write to it latches a 7-bit register pointer and sets the level of a non-maskable-interrupt mask output. The second port is a data port. It reads or writes the byte that the pointer selects, in a 128-entry space.

Seven entries of that space hold the time fields: seconds, minutes, hours, weekday, date, month and year. Two entries hold control and status bytes. Every other entry is plain byte storage. A one-cycle strobe from a 1 Hz source advances the time. The carry passes from seconds through to the year, and the month length follows a leap-year rule. When the update-interrupt enable is set, each accepted tick also sets an update flag and sends an interrupt pulse. Reading the status byte hands its value to software and then clears it.

Address map: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, date 0x07, month 0x08, year 0x09, control 0x0B, status 0x0C. The update-interrupt enable is bit 4 of control. The 24-hour select is bit 1 of control. The update flag is bit 4 of status.

Top module: `rtc_bcd_clock`

## Requirements
- R1: A cycle with `idx_we` high loads `wdata[6:0]` into the register pointer and `wdata[7]` into `nmi_mask`. `nmi_mask` keeps its value on every other cycle. Bit 7 is not part of the address.
- R2: Every address other than the seven time fields, control (0x0B) and status (0x0C) is a byte of storage. A data write followed by a data read at the same pointer returns the written byte. `rdata` always shows the byte at the current pointer.
- R3: Reading status (0x0C) returns its current value in that cycle, and status is zero from the next cycle. Data writes to status are ignored. If a tick sets the update flag in the same cycle as a status read, the flag is still set afterwards.
- R4: An accepted tick advances seconds in BCD. 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wrap to 0x00 and carry into hours. Without an accepted tick or a write to the field, seconds hold.
- R5: A carry out of hours wraps 0x23 to 0x00 and advances both weekday and date. Weekday runs 0x01 to 0x07 and wraps to 0x01.
- R6: A date carry happens after the last day of the month. That day is 0x31, or 0x30 for April, June, September and November. February ends on 0x28, or on 0x29 when the year value is divisible by 4. The date then wraps to 0x01 and the month advances. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R7: With control bit 4 set, an accepted tick sets status bit 4 and drives `upd_irq` high for exactly the following cycle. With control bit 4 clear, a tick changes neither.
- R8: After reset the pointer is 0x00 and `nmi_mask` is 0. Control is 0x02 (24-hour select), status is 0x00 and `upd_irq` is 0. The time is 00:00:00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R9: A data write to any time field in the same cycle as a tick discards that tick. The written field takes the write data, no other field moves, no flag is set and no pulse is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_we | input | 1 | Index-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| data_re | input | 1 | Data-port read strobe (triggers clear of status) |
| wdata | input | 8 | Write data for both ports |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| rdata | output | 8 | Byte at the current pointer |
| nmi_mask | output | 1 | Mask level from bit 7 of the last index write |
| upd_irq | output | 1 | One-cycle update interrupt pulse |

## Verification
On every cycle, the assertions check the following:
- the mask output follows only index writes;
- status clears after a read and ignores writes;
- every interrupt pulse comes from a tick seen with the enable set, and finds the flag already set;
- seconds stay put without a tick;
- a tick that collides with a time write produces no pulse.

The arithmetic of the rollover chain can only be shown by the bench's scenarios. These cover every seconds, minutes and hours start value, and every month end across eight years plus the century wrap. The bench scenarios also cover the storage round trip and the set-beats-clear ordering on status.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg
// Shared constants for the BCD clock: field numbering, register addresses,
// control/status bit positions and the per-field counting limits.
// Assumes 8-bit BCD fields and a 7-bit register pointer.
package rtc_pkg;
    localparam int RTC_DATA_W = 8;
    localparam int RTC_ADDR_W = 7;
    localparam int NUM_FIELDS = 7;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DOM  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam logic [6:0] ADR_CTRL = 7'h0B;
    localparam logic [6:0] ADR_STAT = 7'h0C;

    localparam int UIE_BIT = 4;
    localparam int UF_BIT  = 4;
    localparam logic [7:0] CTRL_RESET = 8'h02;

    // Register address of each time field.
    function automatic logic [6:0] field_addr(input int f);
        case (f)
            F_SEC:   return 7'h00;
            F_MIN:   return 7'h02;
            F_HOUR:  return 7'h04;
            F_DOW:   return 7'h06;
            F_DOM:   return 7'h07;
            F_MON:   return 7'h08;
            default: return 7'h09;
        endcase
    endfunction

    // Value a field wraps to (and resets to).
    function automatic logic [7:0] field_lo(input int f);
        case (f)
            F_DOW, F_DOM, F_MON: return 8'h01;
            default:             return 8'h00;
        endcase
    endfunction

    // Fixed top value of a field; the date's top is computed at run time.
    function automatic logic [7:0] field_hi(input int f);
        case (f)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DOW:        return 8'h07;
            F_DOM:        return 8'h31;
            F_MON:        return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    // Field whose carry enables this one.
    function automatic int field_parent(input int f);
        case (f)
            F_MIN:   return F_SEC;
            F_HOUR:  return F_MIN;
            F_DOW:   return F_HOUR;
            F_DOM:   return F_HOUR;
            F_MON:   return F_DOM;
            F_YEAR:  return F_MON;
            default: return F_SEC;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
// Module rtc_bcd_step
// Combinational next value of one two-digit BCD field. When enabled, a value
// at or above the top value wraps to the low value; otherwise the field
// increments with a decimal carry between digits. Values above the top
// also wrap, so a bad software write recovers on the next step.
module rtc_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         en,
    output logic [W-1:0] nxt
);
    localparam int D = W / 2;

    // Select hold, wrap, tens increment or ones increment.
    always_comb begin
        if (!en) begin
            nxt = cur;
        end else if (cur >= hi) begin
            nxt = lo;
        end else if (cur[D-1:0] >= D'(9)) begin
            nxt = {cur[W-1:D] + 1'b1, {D{1'b0}}};
        end else begin
            nxt = {cur[W-1:D], cur[D-1:0] + 1'b1};
        end
    end
endmodule

// File: rtl/rtc_month_days.sv
// Module rtc_month_days
// Gives the BCD number of the last day of a month. It needs only the
// low bit of the year's tens digit and the low two bits of its ones
// digit, because (10*T + O) mod 4 equals (2*T[0] + O[1:0]) mod 4.
module rtc_month_days #(
    parameter int W = 8
) (
    input  logic [W-1:0] mon_bcd,
    input  logic         yr_tens_lsb,
    input  logic [1:0]   yr_ones_lo,
    output logic [W-1:0] last_day
);
    logic [1:0] yr_mod4;
    logic       leap;

    // Leap test on the BCD year without converting it to binary.
    always_comb begin
        yr_mod4 = {yr_tens_lsb, 1'b0} + yr_ones_lo;
        leap    = (yr_mod4 == 2'd0);
    end

    // Month length lookup.
    always_comb begin
        case (mon_bcd)
            W'(8'h02):                                  last_day = leap ? W'(8'h29) : W'(8'h28);
            W'(8'h04), W'(8'h06), W'(8'h09), W'(8'h11): last_day = W'(8'h30);
            default:                                    last_day = W'(8'h31);
        endcase
    end
endmodule

// File: rtl/rtc_time_chain.sv
// Module rtc_time_chain
// Holds the seven BCD time fields and advances them on a tick through a
// cascaded carry chain: sec -> min -> hour -> (weekday, date) -> month -> year.
// A write strobe for a field overrides that field's step. Assumes the caller
// removes the tick in any cycle that writes a field.
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter int W  = RTC_DATA_W,
    parameter int NF = NUM_FIELDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NF-1:0]        wr_en,
    input  logic [W-1:0]         wr_data,
    output logic [NF-1:0][W-1:0] fields
);
    logic [NF-1:0]        en;
    logic [NF-2:0]        carry;
    logic [NF-1:0][W-1:0] nxt;
    logic [W-1:0]         dom_last;

    rtc_month_days #(.W(W)) u_days (
        .mon_bcd     (fields[F_MON]),
        .yr_tens_lsb (fields[F_YEAR][4]),
        .yr_ones_lo  (fields[F_YEAR][1:0]),
        .last_day    (dom_last)
    );

    for (genvar i = 0; i < NF; i++) begin : g_field
        localparam logic [W-1:0] LO     = W'(field_lo(i));
        localparam logic [W-1:0] HI_FIX = W'(field_hi(i));
        localparam int           PARENT = field_parent(i);
        logic [W-1:0] hi_i;

        if (i == F_DOM) begin : g_hi_dyn
            assign hi_i = dom_last;
        end else begin : g_hi_fix
            assign hi_i = HI_FIX;
        end

        if (i == 0) begin : g_en_tick
            assign en[i] = tick;
        end else begin : g_en_carry
            assign en[i] = carry[PARENT];
        end

        if (i < NF - 1) begin : g_carry
            assign carry[i] = en[i] && (fields[i] >= hi_i);
        end

        rtc_bcd_step #(.W(W)) u_step (
            .cur (fields[i]),
            .lo  (LO),
            .hi  (hi_i),
            .en  (en[i]),
            .nxt (nxt[i])
        );

        // Field register: reset, software write, or chain step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fields[i] <= LO;
            end else if (wr_en[i]) begin
                fields[i] <= wr_data;
            end else begin
                fields[i] <= nxt[i];
            end
        end
    end
endmodule

// File: rtl/rtc_bcd_clock.sv
// Module rtc_bcd_clock (top)
// Index/data register file around the BCD time chain. The index port sets
// the pointer and the NMI mask level. The data port reaches the time fields,
// control, status (clear on read, write ignored) and plain byte storage.
// A tick that collides with a time-field write is dropped.
// Assumes DATA_W = ADDR_W + 1, so the mask bit sits above the address.
module rtc_bcd_clock
    import rtc_pkg::*;
#(
    parameter int ADDR_W = RTC_ADDR_W,
    parameter int DATA_W = RTC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_1hz,
    output logic [DATA_W-1:0] rdata,
    output logic              nmi_mask,
    output logic              upd_irq
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NF    = NUM_FIELDS;

    logic [ADDR_W-1:0]         idx_q;
    logic [DATA_W-1:0]         ctrl_q;
    logic [DATA_W-1:0]         stat_q;
    logic [DATA_W-1:0]         store_q [DEPTH];
    logic [NF-1:0]             is_field;
    logic [NF-1:0][DATA_W-1:0] time_fields;
    logic                      any_field, is_ctrl, is_stat, is_store;
    logic                      tick_ok, upd_set;

    for (genvar f = 0; f < NF; f++) begin : g_dec
        assign is_field[f] = (idx_q == ADDR_W'(field_addr(f)));
    end

    assign any_field = |is_field;
    assign is_ctrl   = (idx_q == ADDR_W'(ADR_CTRL));
    assign is_stat   = (idx_q == ADDR_W'(ADR_STAT));
    assign is_store  = !any_field && !is_ctrl && !is_stat;
    assign tick_ok   = tick_1hz && !(data_we && any_field);
    assign upd_set   = tick_ok && ctrl_q[UIE_BIT];

    rtc_time_chain #(.W(DATA_W), .NF(NF)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ok),
        .wr_en   (data_we ? is_field : '0),
        .wr_data (wdata),
        .fields  (time_fields)
    );

    // Index port: pointer and NMI mask level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            nmi_mask <= 1'b0;
        end else if (idx_we) begin
            idx_q    <= wdata[ADDR_W-1:0];
            nmi_mask <= wdata[DATA_W-1];
        end
    end

    // Control byte: fully writable, 24-hour select set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= DATA_W'(CTRL_RESET);
        end else if (data_we && is_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    // Status byte: cleared by a read, update flag set by a tick (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((data_re && is_stat) ? '0 : stat_q)
                    | (upd_set ? (DATA_W'(1) << UF_BIT) : '0);
        end
    end

    // Update interrupt pulse, one cycle after the accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_irq <= 1'b0;
        end else begin
            upd_irq <= upd_set;
        end
    end

    // General byte storage for every non-special address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                store_q[a] <= '0;
            end
        end else if (data_we && is_store) begin
            store_q[idx_q] <= wdata;
        end
    end

    // Read multiplexer for the current pointer.
    always_comb begin
        rdata = store_q[idx_q];
        if (is_ctrl) rdata = ctrl_q;
        if (is_stat) rdata = stat_q;
        for (int f = 0; f < NF; f++) begin
            if (is_field[f]) rdata = time_fields[f];
        end
    end
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
// Module rtc_bcd_clock_chk
// Property checker bound to rtc_bcd_clock. It watches the port strobes
// together with the pointer, control, status and seconds registers.
module rtc_bcd_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_we,
    input logic       data_we,
    input logic       data_re,
    input logic       tick_1hz,
    input logic [7:0] wdata,
    input logic       nmi_mask,
    input logic       upd_irq,
    input logic [6:0] idx,
    input logic [7:0] ctrl,
    input logic [7:0] stat,
    input logic [7:0] sec
);
    logic idx_time;
    assign idx_time = (idx == 7'h00) || (idx == 7'h02) || (idx == 7'h04) ||
                      (idx == 7'h06) || (idx == 7'h07) || (idx == 7'h08) ||
                      (idx == 7'h09);

    AST_NMI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> (nmi_mask == $past(wdata[7])));                          // R1
    AST_NMI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(nmi_mask));                                     // R1
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && idx == 7'h0C && !tick_1hz) |=> (stat == 8'h00));       // R3
    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !data_re && idx == 7'h0C && !tick_1hz) |=> $stable(stat)); // R3
    AST_SEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !(data_we && idx == 7'h00)) |=> $stable(sec));        // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> ($past(tick_1hz) && $past(ctrl[4])));                   // R7
    AST_IRQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> stat[4]);                                               // R7
    AST_COLLIDE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && data_we && idx_time) |=> !upd_irq);                    // R9
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .data_we  (data_we),
    .data_re  (data_re),
    .tick_1hz (tick_1hz),
    .wdata    (wdata),
    .nmi_mask (nmi_mask),
    .upd_irq  (upd_irq),
    .idx      (idx_q),
    .ctrl     (ctrl_q),
    .stat     (stat_q),
    .sec      (time_fields[0])
);

// File: tb/rtc_bcd_clock_test.sv
`timescale 1ns/1ps
module rtc_bcd_clock_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0, data_we = 1'b0, data_re = 1'b0, tick_1hz = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       nmi_mask, upd_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    rtc_bcd_clock uut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
        .data_re(data_re), .wdata(wdata), .tick_1hz(tick_1hz),
        .rdata(rdata), .nmi_mask(nmi_mask), .upd_irq(upd_irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idx_write(input logic [7:0] v);
        @(negedge clk); idx_we = 1'b1; wdata = v;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        idx_write({1'b0, a});
        @(negedge clk); data_we = 1'b1; wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        idx_write({1'b0, a});
        @(negedge clk); data_re = 1'b1; #1 v = rdata;
        @(negedge clk); data_re = 1'b0;
    endtask

    task automatic do_tick(output logic irq_next, output logic irq_after);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0; #1 irq_next = upd_irq;
        @(negedge clk); #1 irq_after = upd_irq;
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dm, input int mo, input int y);
        wr(7'h00, bcd(s)); wr(7'h02, bcd(mi)); wr(7'h04, bcd(h));
        wr(7'h06, bcd(dw)); wr(7'h07, bcd(dm)); wr(7'h08, bcd(mo));
        wr(7'h09, bcd(y));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic i1, i2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state; the first read uses the reset pointer 0x00
        #1 chk("R8 nmi", {7'b0, nmi_mask}, 8'h00);
        chk("R8 irq", {7'b0, upd_irq}, 8'h00);
        @(negedge clk); data_re = 1'b1; #1 v = rdata;
        @(negedge clk); data_re = 1'b0;
        chk("R8 sec", v, 8'h00);
        rd(7'h02, v); chk("R8 min", v, 8'h00);
        rd(7'h04, v); chk("R8 hour", v, 8'h00);
        rd(7'h06, v); chk("R8 dow", v, 8'h01);
        rd(7'h07, v); chk("R8 dom", v, 8'h01);
        rd(7'h08, v); chk("R8 mon", v, 8'h01);
        rd(7'h09, v); chk("R8 year", v, 8'h00);
        rd(7'h0B, v); chk("R8 ctrl", v, 8'h02);
        rd(7'h0C, v); chk("R8 stat", v, 8'h00);

        // R1: mask bit and address split
        idx_write(8'h85);
        #1 chk("R1 mask set", {7'b0, nmi_mask}, 8'h01);
        @(negedge clk); data_we = 1'b1; wdata = 8'hA5;
        @(negedge clk); data_we = 1'b0;
        chk("R1 mask held", {7'b0, nmi_mask}, 8'h01);
        idx_write(8'h05);
        #1 chk("R1 mask clear", {7'b0, nmi_mask}, 8'h00);
        chk("R1 addr bits", rdata, 8'hA5);

        // R2: storage round trip over every non-special address
        for (int a = 0; a < 128; a++) begin
            if (!(a inside {0, 2, 4, 6, 7, 8, 9, 11, 12}))
                wr(7'(a), 8'(a ^ 8'h5A));
        end
        for (int a = 0; a < 128; a++) begin
            if (!(a inside {0, 2, 4, 6, 7, 8, 9, 11, 12})) begin
                rd(7'(a), v); chk("R2 storage", v, 8'(a ^ 8'h5A));
            end
        end

        // R4: seconds sweep, then minutes sweep
        for (int s = 0; s < 60; s++) begin
            wr(7'h00, bcd(s)); wr(7'h02, bcd(10)); wr(7'h04, bcd(5));
            do_tick(i1, i2);
            rd(7'h00, v); chk("R4 sec", v, bcd((s + 1) % 60));
            rd(7'h02, v); chk("R4 sec carry", v, bcd(s == 59 ? 11 : 10));
        end
        for (int m = 0; m < 60; m++) begin
            wr(7'h00, bcd(59)); wr(7'h02, bcd(m)); wr(7'h04, bcd(7));
            do_tick(i1, i2);
            rd(7'h02, v); chk("R4 min", v, bcd((m + 1) % 60));
            rd(7'h04, v); chk("R4 min carry", v, bcd(m == 59 ? 8 : 7));
        end

        // R5: hours sweep with weekday and date advance
        for (int h = 0; h < 24; h++) begin
            int d;
            d = (h % 7) + 1;
            if (h == 23) d = 7;
            set_time(59, 59, h, d, 10, 5, 20);
            do_tick(i1, i2);
            rd(7'h04, v); chk("R5 hour", v, bcd((h + 1) % 24));
            rd(7'h06, v); chk("R5 dow", v, bcd(h == 23 ? 1 : d));
            rd(7'h07, v); chk("R5 dom", v, bcd(h == 23 ? 11 : 10));
        end

        // R6: every month end over eight years
        for (int y = 0; y < 8; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_time(59, 59, 23, 3, mdays(m, y), m, y);
                do_tick(i1, i2);
                rd(7'h07, v); chk("R6 dom wrap", v, 8'h01);
                rd(7'h08, v); chk("R6 month", v, bcd(m % 12 + 1));
                rd(7'h09, v); chk("R6 year", v, bcd(m == 12 ? y + 1 : y));
            end
        end
        set_time(59, 59, 23, 3, 28, 2, 4);
        do_tick(i1, i2);
        rd(7'h07, v); chk("R6 leap feb 29", v, 8'h29);
        rd(7'h08, v); chk("R6 leap month held", v, 8'h02);
        set_time(59, 59, 23, 3, 31, 12, 99);
        do_tick(i1, i2);
        rd(7'h09, v); chk("R6 century", v, 8'h00);
        rd(7'h08, v); chk("R6 century month", v, 8'h01);

        // R7: no flag without enable
        rd(7'h0C, v);
        do_tick(i1, i2);
        chk("R7 no irq", {7'b0, i1}, 8'h00);
        rd(7'h0C, v); chk("R7 no flag", v, 8'h00);
        // R7: enabled flag and one-cycle pulse
        wr(7'h0B, 8'h12);
        do_tick(i1, i2);
        chk("R7 irq pulse", {7'b0, i1}, 8'h01);
        chk("R7 irq one cycle", {7'b0, i2}, 8'h00);
        // R3: read returns value, then cleared
        rd(7'h0C, v); chk("R3 read value", v, 8'h10);
        rd(7'h0C, v); chk("R3 cleared", v, 8'h00);
        wr(7'h0C, 8'hFF);
        rd(7'h0C, v); chk("R3 write ignored", v, 8'h00);
        // R3: set wins over clear in the same cycle
        idx_write(8'h0C);
        @(negedge clk); data_re = 1'b1; tick_1hz = 1'b1; #1 v = rdata;
        @(negedge clk); data_re = 1'b0; tick_1hz = 1'b0;
        chk("R3 old value", v, 8'h00);
        rd(7'h0C, v); chk("R3 set wins", v, 8'h10);

        // R9: tick dropped on collision with a time write
        set_time(30, 15, 12, 2, 9, 6, 21);
        rd(7'h0C, v);
        idx_write(8'h00);
        @(negedge clk); data_we = 1'b1; wdata = 8'h45; tick_1hz = 1'b1;
        @(negedge clk); data_we = 1'b0; tick_1hz = 1'b0; #1 i1 = upd_irq;
        chk("R9 no irq", {7'b0, i1}, 8'h00);
        rd(7'h00, v); chk("R9 write wins", v, 8'h45);
        rd(7'h02, v); chk("R9 min held", v, 8'h15);
        rd(7'h0C, v); chk("R9 no flag", v, 8'h00);
        idx_write(8'h02);
        @(negedge clk); data_we = 1'b1; wdata = 8'h33; tick_1hz = 1'b1;
        @(negedge clk); data_we = 1'b0; tick_1hz = 1'b0;
        rd(7'h00, v); chk("R9 sec held", v, 8'h45);
        rd(7'h02, v); chk("R9 min written", v, 8'h33);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule